// File: doc/BRIEF.md
# Converter Power-Up Sequencer with Protection Threshold Selection

This block orders the start of a switching converter. While the internal supply is not good or enable is low it stays in shutdown with every output inactive. Once both are high it runs a fixed sensing window. During that window the compensation node is driven to a known level and an external impedance classifier reports a two-bit class. The class seen in the last cycle of the window picks one of three short-circuit thresholds, and that choice is held from then on.

After sensing, the compensation node is clamped low for a fixed preconditioning period so that the loop starts from a known state. Then a digital soft-start reference climbs linearly from zero to full scale, and a run flag marks that regulation has been handed over. A hiccup restart request from the fault logic starts the ramp again from zero without repeating the sensing and clamp phases. Phase lengths are parameters in clock cycles. The defaults give about 2 ms, 4 ms and 4.7 ms at a 200 MHz clock.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After a synchronous reset, sense_drv, comp_clamp and run are 0, ss_ref is 0, and thr_sel is 2'b01 (the 320 mV code).
- R2: Sequencing starts only when supply_ok and en are both 1. In the cycle after the first clock edge that sees both high, sense_drv is 1. With either input low, every output stays inactive.
- R3: sense_drv is high for exactly SENSE_CYCLES cycles. comp_clamp then rises in the next cycle and stays high for exactly CLAMP_CYCLES cycles.
- R4: imp_class is sampled in the last cycle of the sense window. The codes map as follows: 2'b01 (low-resistance class) gives thr_sel 2'b00 (160 mV), 2'b10 (mid-resistance class) gives 2'b10 (460 mV), and 2'b00 (open) or 2'b11 gives 2'b01 (320 mV).
- R5: thr_sel changes only at the end of a sense window. imp_class changes at any other time, restarts and shutdowns leave it unchanged.
- R6: In the first cycle after comp_clamp falls, ss_ref is 0. It then rises by one every STEP_CYCLES cycles until it reaches full scale, 2^REF_W-1.
- R7: run rises in the cycle after ss_ref first shows full scale. While run is 1, ss_ref stays at full scale.
- R8: A restart_req seen while ramping or running gives ss_ref 0 and run 0 in the next cycle, with no sense or clamp phase, and the ramp then repeats. restart_req is ignored during the sense and clamp phases.
- R9: If en or supply_ok is low at a clock edge, then in the next cycle all of sense_drv, comp_clamp and run are 0 and ss_ref is 0, whatever the state. This takes priority over restart_req.
- R10: A restart_req in the cycle in which ss_ref first shows full scale wins over ramp completion: run stays 0 and ss_ref returns to 0.
- R11: At most one of sense_drv, comp_clamp and run is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Internal supply above its turn-on level (hysteresis applied outside) |
| en | input | 1 | Start command; low forces shutdown |
| restart_req | input | 1 | Hiccup restart request from the fault logic |
| imp_class | input | 2 | Impedance class from the external classifier |
| thr_sel | output | 2 | Latched short-circuit threshold code |
| sense_drv | output | 1 | Drive the sense level onto the compensation node |
| comp_clamp | output | 1 | Clamp the compensation node low |
| ss_ref | output | REF_W | Soft-start reference value |
| run | output | 1 | Soft-start complete, converter regulating |

## Verification
Two events can fall in the same cycle: a hiccup restart request and ramp completion. The bench provokes this by raising restart_req in exactly the cycle in which ss_ref first shows full scale. It passes if run never rises and ss_ref is back at 0 in the next cycle. A second collision is also driven: shutdown and restart together, with en dropped in the same cycle as restart_req. The bench expects the fully inactive shutdown outputs rather than a new ramp.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_SENSE = 3'd1,
        ST_CLAMP = 3'd2,
        ST_RAMP  = 3'd3,
        ST_RUN   = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        THR_160 = 2'b00,
        THR_320 = 2'b01,
        THR_460 = 2'b10
    } thr_sel_e;

    localparam logic [1:0] IMP_OPEN = 2'b00;
    localparam logic [1:0] IMP_LOW  = 2'b01;
    localparam logic [1:0] IMP_MID  = 2'b10;

    typedef struct packed {
        logic sense;
        logic clamp;
        logic ramp;
        logic run;
    } phase_ctl_t;

    function automatic thr_sel_e decode_imp(input logic [1:0] cls);
        case (cls)
            IMP_LOW: decode_imp = THR_160;
            IMP_MID: decode_imp = THR_460;
            default: decode_imp = THR_320;
        endcase
    endfunction

    function automatic phase_ctl_t phase_of(input seq_state_e st);
        phase_ctl_t p;
        p = '0;
        case (st)
            ST_SENSE: p.sense = 1'b1;
            ST_CLAMP: p.clamp = 1'b1;
            ST_RAMP:  p.ramp  = 1'b1;
            ST_RUN:   p.run   = 1'b1;
            default:  p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pwrseq_phase_timer.sv
module pwrseq_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    // R3
    timer_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/pwrseq_thr_latch.sv
module pwrseq_thr_latch
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       capture,
    input  logic [1:0] imp_class,
    output thr_sel_e   thr
);

    thr_sel_e thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= THR_320;
        end else if (capture) begin
            thr_q <= decode_imp(imp_class);
        end
    end

    assign thr = thr_q;

    // R5
    thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(thr_q));

    // R4
    thr_legal_chk: assert property (@(posedge clk) disable iff (rst)
        thr_q != 2'b11);

endmodule

// File: rtl/pwrseq_ramp.sv
module pwrseq_ramp #(
    parameter int REF_W       = 10,
    parameter int STEP_CYCLES = 919
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [REF_W-1:0] ref_val,
    output logic             full
);

    localparam logic [REF_W-1:0] REF_MAX = {REF_W{1'b1}};

    logic [REF_W-1:0] ref_q;
    logic             tick_step;

    assign full = (ref_q == REF_MAX);

    generate
        if (STEP_CYCLES <= 1) begin : g_no_prescale
            assign tick_step = 1'b1;
        end else begin : g_prescale
            localparam int STEP_W = $clog2(STEP_CYCLES);
            localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYCLES - 1);
            logic [STEP_W-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    pre_q <= '0;
                end else if (advance && !full) begin
                    if (pre_q == STEP_LAST) begin
                        pre_q <= '0;
                    end else begin
                        pre_q <= pre_q + 1'b1;
                    end
                end
            end

            assign tick_step = (pre_q == STEP_LAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ref_q <= '0;
        end else if (advance && !full && tick_step) begin
            ref_q <= ref_q + 1'b1;
        end
    end

    assign ref_val = ref_q;

    // R6
    ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (ref_q == $past(ref_q)) || (ref_q == $past(ref_q) + 1'b1));

    // R6
    ramp_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (ref_q == '0));

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int SENSE_CYCLES = 400000,
    parameter int CLAMP_CYCLES = 800000,
    parameter int REF_W        = 10,
    parameter int STEP_CYCLES  = 919
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supply_ok,
    input  logic             en,
    input  logic             restart_req,
    input  logic [1:0]       imp_class,
    output logic [1:0]       thr_sel,
    output logic             sense_drv,
    output logic             comp_clamp,
    output logic [REF_W-1:0] ss_ref,
    output logic             run
);

    localparam int PHASE_MAX = (SENSE_CYCLES > CLAMP_CYCLES) ? SENSE_CYCLES : CLAMP_CYCLES;
    localparam int CNT_W     = $clog2(PHASE_MAX + 1);
    localparam logic [CNT_W-1:0] SENSE_LAST = CNT_W'(SENSE_CYCLES - 1);
    localparam logic [CNT_W-1:0] CLAMP_LAST = CNT_W'(CLAMP_CYCLES - 1);
    localparam logic [REF_W-1:0] REF_MAX    = {REF_W{1'b1}};

    seq_state_e       state_q, state_d;
    phase_ctl_t       ph;
    logic             go;
    logic             sense_end, clamp_end, restart_hit;
    logic             timer_clear, ramp_clear, ramp_full;
    logic [CNT_W-1:0] phase_cnt;
    logic [REF_W-1:0] ramp_val;
    thr_sel_e         thr_val;

    assign go          = supply_ok && en;
    assign ph          = phase_of(state_q);
    assign sense_end   = ph.sense && (phase_cnt == SENSE_LAST);
    assign clamp_end   = ph.clamp && (phase_cnt == CLAMP_LAST);
    assign restart_hit = restart_req && (ph.ramp || ph.run);

    always_comb begin
        state_d = state_q;
        if (!go) begin
            state_d = ST_OFF;
        end else begin
            case (state_q)
                ST_OFF:   state_d = ST_SENSE;
                ST_SENSE: state_d = sense_end ? ST_CLAMP : ST_SENSE;
                ST_CLAMP: state_d = clamp_end ? ST_RAMP : ST_CLAMP;
                ST_RAMP:  state_d = restart_req ? ST_RAMP : (ramp_full ? ST_RUN : ST_RAMP);
                ST_RUN:   state_d = restart_req ? ST_RAMP : ST_RUN;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign timer_clear = (state_d != state_q) || !(ph.sense || ph.clamp);
    assign ramp_clear  = !go || restart_hit || !(ph.ramp || ph.run);

    pwrseq_phase_timer #(
        .CNT_W (CNT_W)
    ) i_phase_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (timer_clear),
        .cnt   (phase_cnt)
    );

    pwrseq_thr_latch i_thr_latch (
        .clk       (clk),
        .rst       (rst),
        .capture   (sense_end && go),
        .imp_class (imp_class),
        .thr       (thr_val)
    );

    pwrseq_ramp #(
        .REF_W       (REF_W),
        .STEP_CYCLES (STEP_CYCLES)
    ) i_ramp (
        .clk     (clk),
        .rst     (rst),
        .clear   (ramp_clear),
        .advance (ph.ramp),
        .ref_val (ramp_val),
        .full    (ramp_full)
    );

    assign thr_sel    = thr_val;
    assign sense_drv  = ph.sense;
    assign comp_clamp = ph.clamp;
    assign run        = ph.run;
    assign ss_ref     = ramp_val;

    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OFF && supply_ok && en) |=> sense_drv);

    // R9
    shutdown_chk: assert property (@(posedge clk) disable iff (rst)
        !(supply_ok && en) |=> (!sense_drv && !comp_clamp && !run && ss_ref == '0));

    // R11
    phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sense_drv, comp_clamp, run}));

    // R7
    run_full_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (ss_ref == REF_MAX));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (restart_req && supply_ok && en && (run || state_q == ST_RAMP))
        |=> (!run && ss_ref == '0 && !sense_drv && !comp_clamp));

    // R3
    clamp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (sense_drv && supply_ok && en && phase_cnt == SENSE_LAST) |=> comp_clamp);

endmodule

// File: tb/test_pwrseq_ctrl.sv
`timescale 1ns/1ps
module test_pwrseq_ctrl;

    localparam int SENSE = 12;
    localparam int CLAMP = 20;
    localparam int RW    = 4;
    localparam int STEP  = 3;
    localparam int RMAX  = (1 << RW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          supply_ok = 1'b0;
    logic          en = 1'b0;
    logic          restart_req = 1'b0;
    logic [1:0]    imp_class = 2'b00;
    logic [1:0]    thr_sel;
    logic          sense_drv;
    logic          comp_clamp;
    logic [RW-1:0] ss_ref;
    logic          run;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pwrseq_ctrl #(
        .SENSE_CYCLES (SENSE),
        .CLAMP_CYCLES (CLAMP),
        .REF_W        (RW),
        .STEP_CYCLES  (STEP)
    ) i_pwrseq_ctrl (
        .clk         (clk),
        .rst         (rst),
        .supply_ok   (supply_ok),
        .en          (en),
        .restart_req (restart_req),
        .imp_class   (imp_class),
        .thr_sel     (thr_sel),
        .sense_drv   (sense_drv),
        .comp_clamp  (comp_clamp),
        .ss_ref      (ss_ref),
        .run         (run)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int outs();
        return {sense_drv, comp_clamp, run};
    endfunction

    task automatic check_off(input string req);
        check(outs() == 0 && ss_ref == 0, req, outs() * 100 + int'(ss_ref), 0);
    endtask

    // R6 / R7 / R10: walks the ramp starting at its first sample
    task automatic check_ramp(input bit restart_at_full);
        for (int v = 0; v < RMAX; v++) begin
            int held;
            held = 0;
            while (int'(ss_ref) == v && run == 1'b0 && held < STEP + 4) begin
                held++;
                tick();
            end
            check(held == STEP, "R6 step hold", held, STEP);
        end
        check(int'(ss_ref) == RMAX && run == 1'b0, "R7 full before run",
              int'(ss_ref) * 10 + int'(run), RMAX * 10);
        if (restart_at_full) begin
            restart_req = 1'b1;
            tick();
            restart_req = 1'b0;
            check(run == 1'b0 && ss_ref == 0, "R10 restart beats completion",
                  int'(run) * 100 + int'(ss_ref), 0);
        end else begin
            tick();
            check(run == 1'b1 && int'(ss_ref) == RMAX, "R7 run after full",
                  int'(run) * 100 + int'(ss_ref), 100 + RMAX);
        end
    endtask

    task automatic do_start(input logic [1:0] target, input logic [1:0] wrong,
                            input int exp_thr, input bit restart_in_sense);
        int n;
        int m;
        imp_class = wrong;
        supply_ok = 1'b1;
        en = 1'b1;
        tick();
        check(sense_drv == 1'b1, "R2 sense starts", int'(sense_drv), 1);
        n = 0;
        while (sense_drv && n < SENSE + 5) begin
            n++;
            restart_req = (restart_in_sense && n == 2);
            if (n == SENSE) imp_class = target;
            tick();
        end
        restart_req = 1'b0;
        check(n == SENSE, "R3 sense length (R8 restart ignored)", n, SENSE);
        check(comp_clamp == 1'b1, "R3 clamp follows", int'(comp_clamp), 1);
        check(int'(thr_sel) == exp_thr, "R4 threshold decode", int'(thr_sel), exp_thr);
        imp_class = wrong;
        m = 0;
        while (comp_clamp && m < CLAMP + 5) begin
            m++;
            tick();
        end
        check(m == CLAMP, "R3 clamp length", m, CLAMP);
        check(int'(thr_sel) == exp_thr, "R5 thr held vs imp change", int'(thr_sel), exp_thr);
        check(ss_ref == 0 && outs() == 0, "R6 ramp starts at zero", int'(ss_ref), 0);
        check_ramp(1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) tick();
        check_off("R1 reset outputs");
        check(thr_sel == 2'b01, "R1 reset threshold", int'(thr_sel), 1);
        rst = 1'b0;
        tick();
    endtask

    task automatic t_hold_off();
        supply_ok = 1'b1;
        en = 1'b0;
        repeat (6) tick();
        check_off("R2 enable low holds off");
        supply_ok = 1'b0;
        en = 1'b1;
        repeat (6) tick();
        check_off("R2 supply low holds off");
    endtask

    task automatic t_restart_in_run();
        repeat (5) tick();
        check(run == 1'b1 && int'(ss_ref) == RMAX, "R7 run holds full",
              int'(ss_ref), RMAX);
        imp_class = IMP_LOW_C;
        restart_req = 1'b1;
        tick();
        restart_req = 1'b0;
        check(run == 1'b0 && ss_ref == 0 && !sense_drv && !comp_clamp,
              "R8 restart from run", outs() * 100 + int'(ss_ref), 0);
        check(thr_sel == 2'b10, "R5 thr kept over restart", int'(thr_sel), 2);
        check_ramp(1'b0);
    endtask

    localparam logic [1:0] IMP_LOW_C = 2'b01;

    task automatic t_restart_mid_ramp();
        int guard;
        restart_req = 1'b1;
        tick();
        restart_req = 1'b0;
        guard = 0;
        while (int'(ss_ref) != 5 && guard < 100) begin
            guard++;
            tick();
        end
        check(int'(ss_ref) == 5, "R6 ramp reaches 5", int'(ss_ref), 5);
        restart_req = 1'b1;
        tick();
        restart_req = 1'b0;
        check(ss_ref == 0 && run == 1'b0 && outs() == 0, "R8 restart mid ramp",
              int'(ss_ref), 0);
        check_ramp(1'b0);
    endtask

    task automatic t_restart_at_full();
        restart_req = 1'b1;
        tick();
        restart_req = 1'b0;
        check_ramp(1'b1);
        check_ramp(1'b0);
    endtask

    task automatic t_shutdown_priority();
        en = 1'b0;
        restart_req = 1'b1;
        tick();
        restart_req = 1'b0;
        check_off("R9 shutdown beats restart");
        repeat (5) tick();
        check_off("R9 stays off");
        check(thr_sel == 2'b10, "R5 thr kept over shutdown", int'(thr_sel), 2);
    endtask

    task automatic t_supply_drop();
        int guard;
        en = 1'b0;
        tick();
        imp_class = 2'b00;
        supply_ok = 1'b1;
        en = 1'b1;
        tick();
        guard = 0;
        while (sense_drv && guard < SENSE + 5) begin
            guard++;
            tick();
        end
        check(comp_clamp == 1'b1 && thr_sel == 2'b01, "R4 open class gives 320",
              int'(thr_sel), 1);
        repeat (3) tick();
        supply_ok = 1'b0;
        tick();
        check_off("R9 supply drop in clamp");
        en = 1'b0;
        supply_ok = 1'b1;
        tick();
        check_off("R9 off after drop");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_hold_off();
        do_start(2'b10, 2'b01, 2, 1'b1);
        t_restart_in_run();
        t_restart_mid_ramp();
        t_restart_at_full();
        t_shutdown_priority();
        do_start(2'b01, 2'b00, 0, 1'b0);
        t_supply_drop();
        do_start(2'b11, 2'b10, 1, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule